// File: doc/BRIEF.md
# Privilege-Filtered Performance Counter Bank

This block holds a configurable number of programmable event counters plus one free-running cycle counter. Each event counter watches one line of an incoming vector of single-cycle event pulses, chosen by a 16-bit event number held in its own type register. Every counter increments only when a chain of gates agrees. The chain is a master enable, then a per-counter enable bit, then the prohibited-region rule, then a per-counter filter. The filter compares the current exception level and security state against a handful of filter bits.

Software reaches everything through a flat, word-addressed read/write port. A write lands on the clock edge. Reads are combinational from the address. The map is:
- `0x00 + n`: event counter n.
- `0x1F`: cycle counter.
- `0x20 + n`: event type register n.
- `0x3F`: cycle filter.
- `0x40`: control.
- `0x41`: enable-set.
- `0x42`: enable-clear.

Unmapped addresses read as zero. The level input carries the exception level as a plain binary number (0 to 3), and `ns_i` is 1 in the non-secure state.

Top module: `pmon_bank`

## Requirements
- R1: After reset every counter, type register, the cycle filter, the control register and the enable bits read as zero.
- R2: With control bit 0 (master enable) clear, no counter changes except through a register write, whatever the other settings.
- R3: Writing the enable-set address ORs the written ones into the enable word and writing the enable-clear address clears the written ones; bit n enables event counter n, bit 31 the cycle counter, bits of absent counters read as zero, and a counter whose bit is clear never increments.
- R4: Event counters never increment while `prohibit_i` is high; the cycle counter keeps counting there when control bit 5 is 0 and stops there when it is 1.
- R5: At level 0 the filter always passes; at level 1 it passes when filter bit 31 is 0, and in the non-secure state bit 29 must also equal bit 31.
- R6: At level 2 in the non-secure state the filter passes when bit 27 is 1; in the secure state it passes when bit 24 differs from bit 27.
- R7: At level 3 the filter passes when bit 26 equals bit 31 and bit 31 is 0.
- R8: An event counter adds 1 in a cycle where the event line selected by type bits [15:0] pulses; event numbers at or above `NUM_EVENTS` never count.
- R9: Event counters are `CNT_W` bits wide, the cycle counter is 64 bits wide, and both wrap to zero past their all-ones value; write data above the counter width is dropped.
- R10: A write to a counter in the same cycle as an increment leaves exactly the written value.
- R11: Type and filter registers keep only bits 31, 29, 27, 26, 24 and 15:0, and control keeps only bits 0 and 5; every other bit, including bits 63:32, reads as zero.
- R12: The cycle counter adds exactly 1 per clock while its gate chain passes, filtered by the register at `0x3F` with the same bit rules as R5 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVENTS | One-cycle event pulses, line k is event number k |
| el_i | input | 2 | Current exception level, binary 0 to 3 |
| ns_i | input | 1 | 1 = non-secure state, 0 = secure |
| prohibit_i | input | 1 | Event counting prohibited in the current region |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register word address for reads and writes |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i`, zero-extended |

## Verification
The bench builds the bank with four event counters, twenty event lines and 32-bit event counters, with all optional levels and states present. Twenty lines bring the event-number boundary within reach: number 19 counts, 20 does not, and an extended number above bit 9 does not. Four counters let the bench show enable bits of absent counters reading back as zero. A 32-bit width makes the event-counter wrap and the dropping of upper write data directly testable. The cycle counter is checked for its 64-bit wrap by presetting it to all ones.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

   // filter / type register field positions
   localparam int FB_P   = 31;
   localparam int FB_NSK = 29;
   localparam int FB_NSH = 27;
   localparam int FB_M   = 26;
   localparam int FB_SH  = 24;
   localparam int EVN_W  = 16;
   localparam logic [31:0] FILT_KEEP = 32'hAD00_FFFF;

   // control register bits
   localparam int CTL_E  = 0;
   localparam int CTL_DP = 5;

   // enable word bit of the cycle counter
   localparam int CYC_BIT = 31;

   // register map (word addresses)
   localparam int          ADDR_W     = 8;
   localparam logic [7:0]  A_CNT_BASE = 8'h00;
   localparam logic [7:0]  A_CYC_CNT  = 8'h1F;
   localparam logic [7:0]  A_TYP_BASE = 8'h20;
   localparam logic [7:0]  A_CYC_FLT  = 8'h3F;
   localparam logic [7:0]  A_CTL      = 8'h40;
   localparam logic [7:0]  A_EN_SET   = 8'h41;
   localparam logic [7:0]  A_EN_CLR   = 8'h42;

   typedef enum logic [1:0] {
      LVL0 = 2'd0,
      LVL1 = 2'd1,
      LVL2 = 2'd2,
      LVL3 = 2'd3
   } lvl_e;

   typedef struct packed {
      logic p;
      logic nsk;
      logic nsh;
      logic m;
      logic sh;
   } fbits_t;

   function automatic fbits_t get_fbits(input logic [31:0] r);
      fbits_t f;
      f.p   = r[FB_P];
      f.nsk = r[FB_NSK];
      f.nsh = r[FB_NSH];
      f.m   = r[FB_M];
      f.sh  = r[FB_SH];
      return f;
   endfunction

endpackage

// File: rtl/pmon_filter.sv
module pmon_filter
   import pmon_pkg::*;
#(
   parameter bit HAS_EL2  = 1'b1,
   parameter bit HAS_EL3  = 1'b1,
   parameter bit HAS_SEL2 = 1'b1
) (
   input  fbits_t     f_i,
   input  logic [1:0] el_i,
   input  logic       ns_i,
   output logic       pass_o
);

   lvl_e lvl;
   assign lvl = lvl_e'(el_i);

   logic pass_l1, pass_l2, pass_l3;

   // R5: level 1, the non-secure rule applies only with level 3 present
   generate
      if (HAS_EL3) begin : g_l1_sec
         assign pass_l1 = !f_i.p && (!ns_i || (f_i.nsk == f_i.p));
         // R7
         assign pass_l3 = !f_i.p && (f_i.m == f_i.p);
      end else begin : g_l1_plain
         assign pass_l1 = !f_i.p;
         assign pass_l3 = 1'b0;
      end
   endgenerate

   // R6: level 2, secure rule only with secure level 2 present
   generate
      if (!HAS_EL2) begin : g_no_l2
         assign pass_l2 = 1'b0;
      end else if (HAS_SEL2) begin : g_l2_sec
         assign pass_l2 = ns_i ? f_i.nsh : (f_i.nsh != f_i.sh);
      end else begin : g_l2_ns
         assign pass_l2 = f_i.nsh;
      end
   endgenerate

   always_comb begin
      unique case (lvl)
         LVL0:    pass_o = 1'b1;
         LVL1:    pass_o = pass_l1;
         LVL2:    pass_o = pass_l2;
         default: pass_o = pass_l3;
      endcase
   end

   always_comb begin
      // R5
      lvl0_pass_chk: assert (!(lvl == LVL0) || pass_o);
   end

endmodule

// File: rtl/pmon_evsel.sv
module pmon_evsel
   import pmon_pkg::*;
#(
   parameter int NUM_EVENTS = 64
) (
   input  logic [NUM_EVENTS-1:0] evt_i,
   input  logic [EVN_W-1:0]      evnum_i,
   output logic                  hit_o
);

   generate
      if (NUM_EVENTS < 1 || NUM_EVENTS > (1 << EVN_W)) begin : g_bad_events
         $error("pmon_evsel: NUM_EVENTS out of range");
      end
   endgenerate

   // R8: numbers beyond the vector match no line
   always_comb begin
      hit_o = 1'b0;
      for (int k = 0; k < NUM_EVENTS; k++) begin
         if (evnum_i == EVN_W'(k)) hit_o = evt_i[k];
      end
   end

   always_comb begin
      // R8
      evsel_range_chk: assert (!(evnum_i >= EVN_W'(NUM_EVENTS) && NUM_EVENTS < (1 << EVN_W)) || !hit_o);
   end

endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] cnt_o
);

   generate
      if (W < 2 || W > 64) begin : g_bad_width
         $error("pmon_counter: W out of range");
      end
   endgenerate

   // R10: write wins over an increment in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (wr_i)   cnt_o <= wdata_i;
      else if (inc_i)  cnt_o <= cnt_o + 1'b1;
   end

   // R10
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> cnt_o == $past(wdata_i));

   // R9
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_i && (&cnt_o)) |=> cnt_o == '0);

endmodule

// File: rtl/pmon_bank.sv
module pmon_bank
   import pmon_pkg::*;
#(
   parameter int NUM_EVT_CTR = 31,
   parameter int NUM_EVENTS  = 64,
   parameter int CNT_W       = 32,
   parameter bit HAS_EL2     = 1'b1,
   parameter bit HAS_EL3     = 1'b1,
   parameter bit HAS_SEL2    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVENTS-1:0] evt_i,
   input  logic [1:0]            el_i,
   input  logic                  ns_i,
   input  logic                  prohibit_i,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [63:0]           wdata_i,
   output logic [63:0]           rdata_o
);

   localparam int CYC_W = 64;

   function automatic logic [31:0] en_mask_f(input int n_ctr);
      logic [31:0] m;
      m = '0;
      m[CYC_BIT] = 1'b1;
      for (int n = 0; n < 31; n++) begin
         if (n < n_ctr) m[n] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [31:0] EN_KEEP = en_mask_f(NUM_EVT_CTR);

   generate
      if (NUM_EVT_CTR < 1 || NUM_EVT_CTR > 31) begin : g_bad_count
         $error("pmon_bank: NUM_EVT_CTR must be 1..31");
      end
      if (CNT_W != 32 && CNT_W != 64) begin : g_bad_cnt_w
         $error("pmon_bank: CNT_W must be 32 or 64");
      end
      if (HAS_SEL2 && !HAS_EL2) begin : g_bad_levels
         $error("pmon_bank: secure level 2 needs level 2");
      end
   endgenerate

   // ---------------- global registers ----------------
   logic        ctl_e, ctl_dp;
   logic [31:0] en_q;
   logic [31:0] cyc_flt_q;

   logic wr_ctl, wr_set, wr_clr, wr_cflt, wr_ccnt;
   assign wr_ctl  = wr_en_i && (addr_i == A_CTL);
   assign wr_set  = wr_en_i && (addr_i == A_EN_SET);
   assign wr_clr  = wr_en_i && (addr_i == A_EN_CLR);
   assign wr_cflt = wr_en_i && (addr_i == A_CYC_FLT);
   assign wr_ccnt = wr_en_i && (addr_i == A_CYC_CNT);

   // R11: control keeps only its two implemented bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_e  <= 1'b0;
         ctl_dp <= 1'b0;
      end else if (wr_ctl) begin
         ctl_e  <= wdata_i[CTL_E];
         ctl_dp <= wdata_i[CTL_DP];
      end
   end

   // R3: write-one-to-set and write-one-to-clear views of one word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (wr_set) en_q <= en_q | (wdata_i[31:0] & EN_KEEP);
      else if (wr_clr) en_q <= en_q & ~wdata_i[31:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cyc_flt_q <= '0;
      else if (wr_cflt) cyc_flt_q <= wdata_i[31:0] & FILT_KEEP;
   end

   // ---------------- event counters ----------------
   logic [31:0]      typ_q  [NUM_EVT_CTR];
   logic [CNT_W-1:0] ev_cnt [NUM_EVT_CTR];
   logic [NUM_EVT_CTR-1:0] ev_inc, ev_wr, ev_pass, ev_hit;

   generate
      for (genvar n = 0; n < NUM_EVT_CTR; n++) begin : g_ctr
         logic wr_typ;
         assign wr_typ   = wr_en_i && (addr_i == A_TYP_BASE + ADDR_W'(n));
         assign ev_wr[n] = wr_en_i && (addr_i == A_CNT_BASE + ADDR_W'(n));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      typ_q[n] <= '0;
            else if (wr_typ) typ_q[n] <= wdata_i[31:0] & FILT_KEEP;
         end

         pmon_filter #(
            .HAS_EL2  (HAS_EL2),
            .HAS_EL3  (HAS_EL3),
            .HAS_SEL2 (HAS_SEL2)
         ) u_flt (
            .f_i    (get_fbits(typ_q[n])),
            .el_i   (el_i),
            .ns_i   (ns_i),
            .pass_o (ev_pass[n])
         );

         pmon_evsel #(
            .NUM_EVENTS (NUM_EVENTS)
         ) u_sel (
            .evt_i   (evt_i),
            .evnum_i (typ_q[n][EVN_W-1:0]),
            .hit_o   (ev_hit[n])
         );

         // R2 R3 R4: layered gate chain
         assign ev_inc[n] = ctl_e && en_q[n] && !prohibit_i && ev_pass[n] && ev_hit[n];

         pmon_counter #(
            .W (CNT_W)
         ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (ev_inc[n]),
            .wr_i    (ev_wr[n]),
            .wdata_i (wdata_i[CNT_W-1:0]),
            .cnt_o   (ev_cnt[n])
         );

         // R4
         ev_prohibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (prohibit_i && !ev_wr[n]) |=> $stable(ev_cnt[n]));

         // R3
         ev_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[n] && !ev_wr[n]) |=> $stable(ev_cnt[n]));

         // R2
         ev_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl_e && !ev_wr[n]) |=> $stable(ev_cnt[n]));
      end
   endgenerate

   // ---------------- cycle counter ----------------
   logic             cyc_pass, cyc_inc;
   logic [CYC_W-1:0] cyc_cnt;

   pmon_filter #(
      .HAS_EL2  (HAS_EL2),
      .HAS_EL3  (HAS_EL3),
      .HAS_SEL2 (HAS_SEL2)
   ) u_cyc_flt (
      .f_i    (get_fbits(cyc_flt_q)),
      .el_i   (el_i),
      .ns_i   (ns_i),
      .pass_o (cyc_pass)
   );

   // R4 R12: the prohibit input only matters when DP is set
   assign cyc_inc = ctl_e && en_q[CYC_BIT] && !(ctl_dp && prohibit_i) && cyc_pass;

   pmon_counter #(
      .W (CYC_W)
   ) u_cyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (cyc_inc),
      .wr_i    (wr_ccnt),
      .wdata_i (wdata_i),
      .cnt_o   (cyc_cnt)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rdata_o = '0;
      if (addr_i == A_CYC_CNT) rdata_o = cyc_cnt;
      if (addr_i == A_CYC_FLT) rdata_o = 64'(cyc_flt_q);
      if (addr_i == A_CTL) begin
         rdata_o[CTL_E]  = ctl_e;
         rdata_o[CTL_DP] = ctl_dp;
      end
      if (addr_i == A_EN_SET || addr_i == A_EN_CLR) rdata_o = 64'(en_q);
      for (int n = 0; n < NUM_EVT_CTR; n++) begin
         if (addr_i == A_CNT_BASE + ADDR_W'(n)) rdata_o = 64'(ev_cnt[n]);
         if (addr_i == A_TYP_BASE + ADDR_W'(n)) rdata_o = 64'(typ_q[n]);
      end
   end

   // R2
   cyc_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_e && !wr_ccnt) |=> $stable(cyc_cnt));

   // R3
   cyc_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[CYC_BIT] && !wr_ccnt) |=> $stable(cyc_cnt));

   // R4
   cyc_dp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_dp && prohibit_i && !wr_ccnt) |=> $stable(cyc_cnt));

   // R3
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((en_q & $past(wdata_i[31:0]) & EN_KEEP) == ($past(wdata_i[31:0]) & EN_KEEP)));

   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((en_q & $past(wdata_i[31:0])) == 32'h0));

   // R11
   always_comb begin
      en_keep_chk: assert ((en_q & ~EN_KEEP) == 32'h0);
   end

endmodule

// File: tb/sim_pmon_bank.sv
module sim_pmon_bank;
   import pmon_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NCTR = 4;
   localparam int NEV  = 20;
   localparam int CW   = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NEV-1:0] evt = '0;
   logic [1:0]     el = 2'd0;
   logic           ns = 1'b1;
   logic           prohibit = 1'b0;
   logic           wr_en = 1'b0;
   logic [7:0]     addr = '0;
   logic [63:0]    wdata = '0;
   logic [63:0]    rdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmon_bank #(
      .NUM_EVT_CTR (NCTR),
      .NUM_EVENTS  (NEV),
      .CNT_W       (CW)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .el_i       (el),
      .ns_i       (ns),
      .prohibit_i (prohibit),
      .wr_en_i    (wr_en),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .rdata_o    (rdata)
   );

   // {level, ns, filter word, expected count}
   localparam logic [35:0] VEC [14] = '{
      {2'd0, 1'b1, 32'hAD00_0000, 1'b1},
      {2'd1, 1'b0, 32'h0000_0000, 1'b1},
      {2'd1, 1'b0, 32'h8000_0000, 1'b0},
      {2'd1, 1'b1, 32'h0000_0000, 1'b1},
      {2'd1, 1'b1, 32'h2000_0000, 1'b0},
      {2'd1, 1'b1, 32'hA000_0000, 1'b0},
      {2'd2, 1'b1, 32'h0800_0000, 1'b1},
      {2'd2, 1'b1, 32'h0000_0000, 1'b0},
      {2'd2, 1'b0, 32'h0800_0000, 1'b1},
      {2'd2, 1'b0, 32'h0900_0000, 1'b0},
      {2'd2, 1'b0, 32'h0100_0000, 1'b1},
      {2'd3, 1'b0, 32'h0000_0000, 1'b1},
      {2'd3, 1'b0, 32'h0400_0000, 1'b0},
      {2'd3, 1'b0, 32'h8400_0000, 1'b0}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic pulse(input logic [NEV-1:0] m);
      @(negedge clk);
      evt = m;
      @(negedge clk);
      evt = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] v, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(A_CNT_BASE, v);     check("R1 counter0", v, 0);
      rd(A_CYC_CNT, v);      check("R1 cycle", v, 0);
      rd(A_CTL, v);          check("R1 control", v, 0);
      rd(A_EN_SET, v);       check("R1 enables", v, 0);
      rd(A_TYP_BASE + 3, v); check("R1 type3", v, 0);

      // R3: set with all ones keeps only present counters and bit 31
      wr(A_EN_SET, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(A_EN_CLR, v); check("R3 enable mask", v, 64'h8000_000F);

      // R2: master enable clear blocks everything
      wr(A_TYP_BASE, 64'h3);
      pulse(NEV'(1) << 3);
      rd(A_CNT_BASE, v); check("R2 event held", v, 0);
      rd(A_CYC_CNT, v);  check("R2 cycle held", v, 0);

      // R12: cycle counter rate
      wr(A_CTL, 64'h1);
      rd(A_CYC_CNT, v);
      repeat (4) @(negedge clk);
      rd(A_CYC_CNT, v2); check("R12 cycle rate", v2 - v, 5);

      // R3: clear counter1 enable
      wr(A_EN_CLR, 64'h2);
      rd(A_EN_SET, v); check("R3 clear", v, 64'h8000_000D);
      wr(A_TYP_BASE + 1, 64'h3);
      pulse(NEV'(1) << 3);
      rd(A_CNT_BASE, v);     check("R3 enabled counts", v, 1);
      rd(A_CNT_BASE + 1, v); check("R3 disabled held", v, 0);

      // R5/R6/R7: filter table on counter 0, event 3
      foreach (VEC[i]) begin
         wr(A_TYP_BASE, 64'(VEC[i][32:1] | 32'h3));
         wr(A_CNT_BASE, 64'h0);
         el = VEC[i][35:34];
         ns = VEC[i][33];
         pulse(NEV'(1) << 3);
         rd(A_CNT_BASE, v);
         check($sformatf("R5/R6/R7 filter vector %0d", i), v, 64'(VEC[i][0]));
      end
      el = 2'd0; ns = 1'b1;

      // R8: event number boundaries
      wr(A_TYP_BASE, 64'd19);
      wr(A_CNT_BASE, 64'h0);
      pulse(NEV'(1) << 19);
      rd(A_CNT_BASE, v); check("R8 last event line", v, 1);
      wr(A_TYP_BASE, 64'd20);
      pulse('1);
      rd(A_CNT_BASE, v); check("R8 number past vector", v, 1);
      wr(A_TYP_BASE, 64'h403);
      pulse('1);
      rd(A_CNT_BASE, v); check("R8 extended number", v, 1);

      // R9: wraps and width
      wr(A_TYP_BASE, 64'h3);
      wr(A_CNT_BASE, 64'hFFFF_FFFF);
      pulse(NEV'(1) << 3);
      rd(A_CNT_BASE, v); check("R9 event wrap", v, 0);
      wr(A_CNT_BASE, 64'h1_0000_0005);
      rd(A_CNT_BASE, v); check("R9 upper bits dropped", v, 5);
      wr(A_CYC_CNT, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(A_CYC_CNT, v); check("R9 cycle wrap", v, 0);

      // R10: write beats increment
      @(negedge clk);
      wr_en = 1'b1; addr = A_CNT_BASE; wdata = 64'd100; evt = NEV'(1) << 3;
      @(negedge clk);
      wr_en = 1'b0; evt = '0;
      rd(A_CNT_BASE, v); check("R10 write priority", v, 100);

      // R11: reserved bits
      wr(A_TYP_BASE + 2, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(A_TYP_BASE + 2, v); check("R11 type keep", v, 64'hAD00_FFFF);
      wr(A_CYC_FLT, 64'hFFFF_FFFF_0000_0000);
      rd(A_CYC_FLT, v); check("R11 filter upper", v, 0);
      wr(A_CTL, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(A_CTL, v); check("R11 control keep", v, 64'h21);
      wr(A_CTL, 64'h1);

      // R4: prohibited regions
      prohibit = 1'b1;
      rd(A_CYC_CNT, v); rd(A_CYC_CNT, v2);
      check("R4 cycle with DP clear", v2 - v, 1);
      wr(A_CNT_BASE, 64'h0);
      pulse(NEV'(1) << 3);
      rd(A_CNT_BASE, v); check("R4 event prohibited", v, 0);
      wr(A_CTL, 64'h21);
      rd(A_CYC_CNT, v); rd(A_CYC_CNT, v2);
      check("R4 cycle with DP set", v2 - v, 0);
      prohibit = 1'b0;
      rd(A_CYC_CNT, v); rd(A_CYC_CNT, v2);
      check("R4 cycle resumes", v2 - v, 1);

      // R12: cycle filter
      wr(A_CYC_FLT, 64'h8000_0000);
      el = 2'd1;
      rd(A_CYC_CNT, v); rd(A_CYC_CNT, v2);
      check("R12 cycle filtered", v2 - v, 0);
      el = 2'd0;
      rd(A_CYC_CNT, v); rd(A_CYC_CNT, v2);
      check("R12 cycle level0", v2 - v, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule